// File: doc/BRIEF.md
# Auto-Incrementing Memory Pointer Port

This block sits between a processor's external data bus and a memory port and provides two identical 16-bit data pointers. Software loads each pointer one byte at a time through a high and a low pointer register. It then reads or writes the data port of that pointer. A port access reaches the memory location the pointer holds, not the port's own address. When stepping is enabled, the pointer advances by one after the access. A program can therefore walk a buffer with one bus access per byte and no address arithmetic.

A setup register turns the two data ports on and off, and it turns stepping on and off. While the ports are on, they occupy two fixed addresses, and the memory behind those addresses cannot be reached. While the ports are off, those two addresses are ordinary memory. The block's own five registers never reach memory. Every other access passes through unchanged. The memory is assumed to return read data in the same cycle as the address. The read path is combinational from end to end.

Top module: `autoptr_port`

## Requirements
- R1: After reset, both pointers are 0x0000 and the setup register is 0. Reads of all five block registers return 0x00.
- R2: The pointer registers sit at fixed addresses. Pointer 0 high is at 0xE671 and pointer 0 low is at 0xE672. Pointer 1 high is at 0xE673 and pointer 1 low is at 0xE674. Each can be written and read back. An access to any block register (0xE670 to 0xE674) never asserts mem_rd or mem_wr.
- R3: The setup register is at 0xE670. Bit 0 enables the data ports and bit 1 enables stepping. Only these two bits are stored, and the upper bits read as 0.
- R4: While bit 0 of the setup register is 0, accesses to 0xE67B and 0xE67C reach memory at those addresses, with no effect on the pointers.
- R5: While the ports are enabled, an access to 0xE67B drives mem_addr with pointer 0. The strobe and write data pass through, and memory read data returns on cpu_rdata.
- R6: While the ports are enabled, an access to 0xE67C uses pointer 1 in the same way.
- R7: A port access advances its pointer by one on the following clock edge when stepping is enabled, for reads and writes alike. With stepping disabled, the pointer holds its value.
- R8: A pointer that steps from 0xFFFF becomes 0x0000.
- R9: Any other address reaches memory unchanged, with the same strobe and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Processor read strobe, one cycle per access |
| cpu_wr | input | 1 | Processor write strobe, one cycle per access |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Read data returned to the processor |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |

## Verification
The assertions assume that cpu_rd and cpu_wr are never asserted together. They also assume that each asserted cycle is exactly one access, so that one strobe cycle gives exactly one pointer step. The bench drives one operation per clock, with a single strobe. It drops the strobe directly after the edge that completes the access, so no access is ever counted twice. The memory model in the bench answers combinationally from the address, which matches the assumed same-cycle read.

// File: rtl/autoptr_port.sv
`timescale 1ns/1ps
module autoptr_port #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [15:0] REG_BASE = 16'hE670,
  parameter logic [15:0] PORT0    = 16'hE67B,
  parameter logic [15:0] PORT1    = 16'hE67C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int HW = AW - DW;
  localparam logic [AW-1:0] A_CFG = AW'(REG_BASE);
  localparam logic [AW-1:0] A_P0H = AW'(REG_BASE + 16'd1);
  localparam logic [AW-1:0] A_P0L = AW'(REG_BASE + 16'd2);
  localparam logic [AW-1:0] A_P1H = AW'(REG_BASE + 16'd3);
  localparam logic [AW-1:0] A_P1L = AW'(REG_BASE + 16'd4);

  logic [1:0]    cfg;
  logic [AW-1:0] ptr0, ptr1;

  wire port_en = cfg[0];
  wire step_en = cfg[1];
  wire acc     = cpu_rd | cpu_wr;
  wire hit0    = port_en && (cpu_addr == AW'(PORT0));
  wire hit1    = port_en && (cpu_addr == AW'(PORT1));
  wire is_reg  = (cpu_addr >= A_CFG) && (cpu_addr <= A_P1L);

  assign mem_addr  = hit0 ? ptr0 : hit1 ? ptr1 : cpu_addr;
  assign mem_rd    = cpu_rd & ~is_reg;
  assign mem_wr    = cpu_wr & ~is_reg;
  assign mem_wdata = cpu_wdata;

  always_comb begin
    cpu_rdata = mem_rdata;
    if (is_reg) begin
      cpu_rdata = '0;
      case (cpu_addr)
        A_CFG:   cpu_rdata = DW'(cfg);
        A_P0H:   cpu_rdata = DW'(ptr0[AW-1:DW]);
        A_P0L:   cpu_rdata = ptr0[DW-1:0];
        A_P1H:   cpu_rdata = DW'(ptr1[AW-1:DW]);
        A_P1L:   cpu_rdata = ptr1[DW-1:0];
        default: cpu_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      ptr0 <= '0;
      ptr1 <= '0;
    end else begin
      if (cpu_wr) begin
        case (cpu_addr)
          A_CFG: cfg <= cpu_wdata[1:0];
          A_P0H: ptr0[AW-1:DW] <= cpu_wdata[HW-1:0];
          A_P0L: ptr0[DW-1:0]  <= cpu_wdata;
          A_P1H: ptr1[AW-1:DW] <= cpu_wdata[HW-1:0];
          A_P1L: ptr1[DW-1:0]  <= cpu_wdata;
          default: ;
        endcase
      end
      if (acc && step_en && hit0) ptr0 <= ptr0 + 1'b1;
      if (acc && step_en && hit1) ptr1 <= ptr1 + 1'b1;
    end
  end

  AST_REG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_reg) |-> (!mem_rd && !mem_wr)); // R2
  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !port_en) |-> (mem_addr == cpu_addr)); // R4
  AST_OFF_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !port_en && cpu_addr == AW'(PORT0)) |=> $stable(ptr0)); // R4
  AST_STEP0: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit0 && step_en) |=> (ptr0 == $past(ptr0) + 1'b1)); // R7
  AST_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit1 && step_en) |=> (ptr1 == $past(ptr1) + 1'b1)); // R7
  AST_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit1 && !step_en) |=> $stable(ptr1)); // R7
  AST_WRAP0: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit0 && step_en && ptr0 == '1) |=> (ptr0 == '0)); // R8
  AST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !is_reg && !hit0 && !hit1) |-> (mem_addr == cpu_addr && mem_rd == cpu_rd)); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R9
endmodule

// File: tb/autoptr_port_bench.sv
`timescale 1ns/1ps
module autoptr_port_bench;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_rdata, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;
  logic mem_rd, mem_wr;
  int checks = 0, fails = 0;
  bit done = 0;

  int m_cfg;
  int m_ptr[2];

  always #4 clk = ~clk;

  function automatic logic [7:0] memfn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign mem_rdata = memfn(mem_addr);

  autoptr_port u_autoptr_port (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic op(input bit wr, input logic [15:0] a, input logic [7:0] d, input string req);
    bit isreg, ewr, erd, bad;
    logic [15:0] ea;
    logic [7:0] ed;
    int k;
    @(negedge clk);
    cpu_addr = a; cpu_wr = wr; cpu_rd = !wr; cpu_wdata = d;
    #1;
    isreg = (a >= 16'hE670 && a <= 16'hE674);
    k = -1;
    if (!isreg && (m_cfg & 1) && a == 16'hE67B) k = 0;
    if (!isreg && (m_cfg & 1) && a == 16'hE67C) k = 1;
    ea = (k >= 0) ? m_ptr[k][15:0] : a;
    erd = !isreg && !wr;
    ewr = !isreg && wr;
    if (isreg) begin
      case (a)
        16'hE670: ed = 8'(m_cfg);
        16'hE671: ed = 8'(m_ptr[0] >> 8);
        16'hE672: ed = 8'(m_ptr[0]);
        16'hE673: ed = 8'(m_ptr[1] >> 8);
        default:  ed = 8'(m_ptr[1]);
      endcase
    end else ed = memfn(ea);
    bad = (mem_rd !== erd) || (mem_wr !== ewr);
    if (!isreg && mem_addr !== ea) bad = 1;
    if (!wr && cpu_rdata !== ed) bad = 1;
    if (ewr && mem_wdata !== d) bad = 1;
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s a=%h: addr %h/%h rd %b/%b wr %b/%b rdata %h/%h (actual/expected)",
               req, a, mem_addr, ea, mem_rd, erd, mem_wr, ewr, cpu_rdata, ed);
    end
    @(posedge clk);
    if (wr) begin
      case (a)
        16'hE670: m_cfg = d & 3;
        16'hE671: m_ptr[0] = (m_ptr[0] & 'hFF) | (int'(d) << 8);
        16'hE672: m_ptr[0] = (m_ptr[0] & 'hFF00) | int'(d);
        16'hE673: m_ptr[1] = (m_ptr[1] & 'hFF) | (int'(d) << 8);
        16'hE674: m_ptr[1] = (m_ptr[1] & 'hFF00) | int'(d);
        default: ;
      endcase
    end
    if (k >= 0 && (m_cfg & 2) != 0) m_ptr[k] = (m_ptr[k] + 1) & 'hFFFF;
    #1 cpu_rd = 0; cpu_wr = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_cfg = 0; m_ptr[0] = 0; m_ptr[1] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int a = 16'hE670; a <= 16'hE674; a++) op(0, 16'(a), 0, "R1");
    op(1, 16'hE670, 8'hFC, "R3"); op(0, 16'hE670, 0, "R3");
    op(1, 16'hE670, 8'hFF, "R3"); op(0, 16'hE670, 0, "R3");
    op(1, 16'hE670, 8'h00, "R3");
    op(1, 16'hE671, 8'h12, "R2"); op(1, 16'hE672, 8'h34, "R2");
    op(1, 16'hE673, 8'hAB, "R2"); op(1, 16'hE674, 8'hCD, "R2");
    for (int a = 16'hE671; a <= 16'hE674; a++) op(0, 16'(a), 0, "R2");
    op(0, 16'hE67B, 0, "R4"); op(1, 16'hE67C, 8'h77, "R4");
    op(0, 16'hE672, 0, "R4");
    op(0, 16'h1234, 0, "R9"); op(1, 16'h0042, 8'h99, "R9"); op(0, 16'hE67D, 0, "R9");
    op(1, 16'hE670, 8'h01, "R5");
    op(0, 16'hE67B, 0, "R5"); op(0, 16'hE67B, 0, "R7");
    op(1, 16'hE67B, 8'hC3, "R5");
    op(0, 16'hE67C, 0, "R6"); op(1, 16'hE67C, 8'h3C, "R6");
    op(1, 16'hE670, 8'h03, "R7");
    op(0, 16'hE67B, 0, "R7"); op(0, 16'hE67B, 0, "R7");
    op(1, 16'hE67B, 8'h11, "R7"); op(0, 16'hE672, 0, "R7");
    op(0, 16'hE67C, 0, "R7"); op(0, 16'hE674, 0, "R7");
    op(1, 16'hE673, 8'hFF, "R8"); op(1, 16'hE674, 8'hFF, "R8");
    op(0, 16'hE67C, 0, "R8"); op(0, 16'hE67C, 0, "R8");
    op(0, 16'hE673, 0, "R8"); op(0, 16'hE674, 0, "R8");
    op(0, 16'h8000, 0, "R9");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule